// File: doc/BRIEF.md
# Quarter-Wave Sine Reference Generator

This block produces a signed digital sine reference at the fundamental output frequency of a single-phase inverter modulator. Only one quarter of a period is stored: nineteen magnitude samples spaced 5° apart, from 0° through 90° inclusive. The full period is rebuilt by reflecting the table address in the second and fourth quadrants and negating the sample in the second half. A position counter walks the 72 steps of one period. It advances once for each step-enable pulse from the carrier timing logic. A 3600 Hz step rate gives a 50 Hz sine.

An 8-bit unsigned amplitude scale multiplies every stored sample before output, and the product is truncated back to the sample width. This sets the modulation index, and through it the inverter output voltage. Alongside the sample, the block drives a square polarity pulse at the same fundamental rate and its logical complement. The pulse is high during the positive half-period. Both signals are meant to steer the low-frequency inverter leg and to gate the comparator outputs.

Top module: `sine_ref_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the position is 0°, `sine_out` is 0, `pol_pos` is 1 and `pol_neg` is 0.
- R2: The position advances by exactly one step on each clock edge where `step_en` is 1, holds while `step_en` is 0, and wraps from step 71 back to step 0, so one period is 72 steps.
- R3: With default widths the stored magnitude at index i (0..18) is T[i] = round(32767 * sin(5*i degrees)), with exact halves rounded up; T[0] = 0 and T[18] = 32767.
- R4: At step p the table index and sign are: p in 0..17 gives index p, positive; p in 18..35 gives index 36-p, positive; p in 36..53 gives index p-36, negated; p in 54..71 gives index 72-p, negated. Step 18 reads index 18 once, and step 54 reads it once negated.
- R5: The output magnitude is floor(T[index] * S / 256), where S is the unsigned 8-bit `amp_scale`, so S = 0 forces a zero output.
- R6: `sine_out` is two's complement, and a negated sample is the exact arithmetic negative of the positive magnitude.
- R7: `pol_pos` is 1 for steps 0..35 and 0 for steps 36..71, and `pol_neg` is always its complement.
- R8: All three outputs are registered. They reflect the position and `amp_scale` as they stand after the same clock edge, so a scale change appears one cycle later even without a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | One-cycle pulse that advances the position by 5° |
| amp_scale | input | 8 | Unsigned amplitude multiplier, scale S/256 |
| sine_out | output | 16 | Signed sine sample |
| pol_pos | output | 1 | Fundamental-rate polarity pulse, high in the positive half |
| pol_neg | output | 1 | Complement of `pol_pos` |

## Verification
The assertions assume `step_en` is a clean synchronous level that may stay high for consecutive cycles. They also assume `amp_scale` changes only between clock edges, so the zero-scale check can compare against the previous cycle's scale. The stimulus drives both inputs on the falling edge only and leaves `step_en` low during reset. It samples outputs one falling edge after each step or scale change, which keeps every change inside the single-register latency the properties expect. The walk spans several full periods and crosses every quadrant boundary, so the wrap and reflection properties are triggered repeatedly.

// File: rtl/sine_ref_pkg.sv
package sine_ref_pkg;

    // Geometry of one period: 18 steps of 5 degrees per quadrant.
    localparam int QTR_STEPS   = 18;
    localparam int TBL_LEN     = QTR_STEPS + 1;
    localparam int HALF_STEPS  = 2 * QTR_STEPS;
    localparam int CYCLE_STEPS = 4 * QTR_STEPS;
    localparam int IDX_W       = $clog2(TBL_LEN);
    localparam int BASE_W      = 15;

    typedef enum logic [1:0] {
        QD_RISE = 2'd0,
        QD_FALL = 2'd1,
        QD_DIVE = 2'd2,
        QD_RETN = 2'd3
    } quad_e;

    // Quarter-wave magnitudes at 15-bit full scale, round(32767*sin(5i deg)).
    function automatic logic [BASE_W-1:0] base_mag(input logic [IDX_W-1:0] idx);
        logic [BASE_W-1:0] m;
        case (idx)
            5'd0:    m = 15'd0;
            5'd1:    m = 15'd2856;
            5'd2:    m = 15'd5690;
            5'd3:    m = 15'd8481;
            5'd4:    m = 15'd11207;
            5'd5:    m = 15'd13848;
            5'd6:    m = 15'd16384;
            5'd7:    m = 15'd18794;
            5'd8:    m = 15'd21062;
            5'd9:    m = 15'd23170;
            5'd10:   m = 15'd25101;
            5'd11:   m = 15'd26841;
            5'd12:   m = 15'd28377;
            5'd13:   m = 15'd29697;
            5'd14:   m = 15'd30791;
            5'd15:   m = 15'd31650;
            5'd16:   m = 15'd32269;
            5'd17:   m = 15'd32642;
            5'd18:   m = 15'd32767;
            default: m = 15'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sine_ptr.sv
module sine_ptr
    import sine_ref_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] ptr_d
);

    localparam logic [PTR_W-1:0] LAST_STEP = PTR_W'(CYCLE_STEPS - 1);

    typedef struct packed {
        logic [PTR_W-1:0] pos;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            if (st_q.pos == LAST_STEP) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_q = st_q.pos;
    assign ptr_d = st_d.pos;

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST_STEP) else $error("position out of range"); // R2

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ptr_q == LAST_STEP) |=> (ptr_q == '0)) else $error("no wrap"); // R2

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(ptr_q)) else $error("moved without step"); // R2

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ptr_q != LAST_STEP) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)))
        else $error("missed step"); // R2

endmodule

// File: rtl/sine_fold.sv
module sine_fold
    import sine_ref_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter int SAMPLE_W = 16,
    parameter int SCALE_W  = 8
) (
    input  logic [PTR_W-1:0]           pos,
    input  logic [SCALE_W-1:0]         scale,
    output logic signed [SAMPLE_W-1:0] sample,
    output logic                       positive
);

    localparam int MAG_W  = SAMPLE_W - 1;
    localparam int PROD_W = MAG_W + SCALE_W;

    quad_e             quad;
    logic [IDX_W-1:0]  k;
    logic [IDX_W-1:0]  idx;
    logic [BASE_W-1:0] raw;
    logic [MAG_W-1:0]  mag;
    logic [PROD_W-1:0] prod;
    logic [MAG_W-1:0]  scaled;
    logic [SAMPLE_W-1:0] pos_val;

    // Quadrant decode and offset within the quadrant.
    always_comb begin
        if (pos < PTR_W'(QTR_STEPS)) begin
            quad = QD_RISE;
            k    = IDX_W'(pos);
        end else if (pos < PTR_W'(HALF_STEPS)) begin
            quad = QD_FALL;
            k    = IDX_W'(pos - PTR_W'(QTR_STEPS));
        end else if (pos < PTR_W'(HALF_STEPS + QTR_STEPS)) begin
            quad = QD_DIVE;
            k    = IDX_W'(pos - PTR_W'(HALF_STEPS));
        end else begin
            quad = QD_RETN;
            k    = IDX_W'(pos - PTR_W'(HALF_STEPS + QTR_STEPS));
        end
    end

    // Mirror the address in the falling quadrants.
    always_comb begin
        if (quad == QD_FALL || quad == QD_RETN) begin
            idx = IDX_W'(QTR_STEPS) - k;
        end else begin
            idx = k;
        end
        raw = base_mag(idx);
    end

    // Fit the 15-bit table to the chosen magnitude width.
    generate
        if (MAG_W >= BASE_W) begin : g_widen
            assign mag = MAG_W'(raw) << (MAG_W - BASE_W);
        end else begin : g_narrow
            assign mag = MAG_W'(raw >> (BASE_W - MAG_W));
        end
    endgenerate

    // Amplitude scale S/2^SCALE_W, truncated.
    always_comb begin
        prod     = PROD_W'(mag) * PROD_W'(scale);
        scaled   = prod[PROD_W-1:SCALE_W];
        pos_val  = {1'b0, scaled};
        positive = (quad == QD_RISE) || (quad == QD_FALL);
        if (positive) begin
            sample = $signed(pos_val);
        end else begin
            sample = -$signed(pos_val);
        end
    end

endmodule

// File: rtl/sine_ref_gen.sv
module sine_ref_gen
    import sine_ref_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter int SAMPLE_W = 16,
    parameter int SCALE_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_en,
    input  logic [SCALE_W-1:0]         amp_scale,
    output logic signed [SAMPLE_W-1:0] sine_out,
    output logic                       pol_pos,
    output logic                       pol_neg
);

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] sample;
        logic                       pol;
        logic                       pol_n;
    } out_state_t;

    logic [PTR_W-1:0]           ptr_q;
    logic [PTR_W-1:0]           ptr_d;
    logic signed [SAMPLE_W-1:0] fold_sample;
    logic                       fold_pos;
    out_state_t                 out_d, out_q;

    sine_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .ptr_q   (ptr_q),
        .ptr_d   (ptr_d)
    );

    sine_fold #(.PTR_W(PTR_W), .SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W)) u_fold (
        .pos      (ptr_d),
        .scale    (amp_scale),
        .sample   (fold_sample),
        .positive (fold_pos)
    );

    always_comb begin
        out_d        = out_q;
        out_d.sample = fold_sample;
        out_d.pol    = fold_pos;
        out_d.pol_n  = ~fold_pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.sample <= '0;
            out_q.pol    <= 1'b1;
            out_q.pol_n  <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sine_out = out_q.sample;
    assign pol_pos  = out_q.pol;
    assign pol_neg  = out_q.pol_n;

    AST_POL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        pol_pos == (ptr_q < PTR_W'(HALF_STEPS))) else $error("pulse vs position"); // R7

    AST_POL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        pol_pos != pol_neg) else $error("pulse pair not complementary"); // R7

    AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
        pol_pos |-> (sine_out >= 0)) else $error("negative in positive half"); // R4

    AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_pos |-> (sine_out <= 0)) else $error("positive in negative half"); // R6

    AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(amp_scale) == '0) |-> (sine_out == 0)) else $error("zero scale leaked"); // R5

    AST_PEAK_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == '0 || ptr_q == PTR_W'(HALF_STEPS)) |-> (sine_out == 0))
        else $error("zero crossing not zero"); // R4

endmodule

// File: tb/sim_sine_ref_gen.sv
module sim_sine_ref_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {steps to apply, amp_scale}
    localparam int VEC [NVEC][2] = '{
        '{1, 255}, '{5, 128}, '{12, 200}, '{18, 255}, '{1, 64},
        '{17, 255}, '{20, 1}, '{36, 255}, '{0, 0}, '{50, 100}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step_en = 1'b0;
    logic [7:0]        amp_scale = 8'd255;
    logic signed [15:0] sine_out;
    logic              pol_pos;
    logic              pol_neg;

    int checks = 0;
    int failures = 0;
    int ref_pos = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sine_ref_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .amp_scale (amp_scale),
        .sine_out  (sine_out),
        .pol_pos   (pol_pos),
        .pol_neg   (pol_neg)
    );

    function automatic int tbl(input int i);
        real v;
        v = 32767.0 * $sin(real'(i) * 5.0 * 3.14159265358979 / 180.0);
        return $rtoi(v + 0.500001);
    endfunction

    function automatic int expect_sample(input int p, input int s);
        int idx;
        int mag;
        bit neg;
        if (p < 18)      begin idx = p;      neg = 0; end
        else if (p < 36) begin idx = 36 - p; neg = 0; end
        else if (p < 54) begin idx = p - 36; neg = 1; end
        else             begin idx = 72 - p; neg = 1; end
        mag = (tbl(idx) * s) / 256;
        return neg ? -mag : mag;
    endfunction

    task automatic check_int(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (pos=%0d)", req, act, exp_v, ref_pos);
        end
    endtask

    task automatic check_all(input string req);
        check_int(req, int'(sine_out), expect_sample(ref_pos, int'(amp_scale)));
        check_int({req, " R7 pol_pos"}, int'(pol_pos), (ref_pos < 36) ? 1 : 0);
        check_int({req, " R7 pol_neg"}, int'(pol_neg), (ref_pos < 36) ? 0 : 1);
    endtask

    task automatic step_once();
        @(negedge clk) step_en = 1'b1;
        @(negedge clk) step_en = 1'b0;
        ref_pos = (ref_pos + 1) % 72;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // Vector walk: R2, R5, R8
        for (int v = 0; v < NVEC; v++) begin
            amp_scale = 8'(VEC[v][1]);
            @(negedge clk);
            for (int n = 0; n < VEC[v][0]; n++) step_once();
            check_all("R2 R5 vector");
        end

        // Full sweep at scale 255, all quadrant boundaries: R3, R4, R6
        amp_scale = 8'd255;
        while (ref_pos != 0) step_once();
        @(negedge clk);
        for (int n = 0; n < 72; n++) begin
            step_once();
            check_all("R3 R4 R6 sweep");
        end
        // Direct peak checks against the table definition: R3
        while (ref_pos != 18) step_once();
        check_int("R3 peak", int'(sine_out), (32767 * 255) / 256);
        while (ref_pos != 54) step_once();
        check_int("R6 trough", int'(sine_out), -((32767 * 255) / 256));

        // Hold with step_en low: R2
        repeat (12) @(negedge clk);
        check_all("R2 hold");

        // Scale change without a step shows one cycle later: R8
        amp_scale = 8'd40;
        @(negedge clk);
        check_all("R8 scale update");
        amp_scale = 8'd0;
        @(negedge clk);
        check_int("R5 zero scale", int'(sine_out), 0);

        // Wrap 71 -> 0: R2
        amp_scale = 8'd255;
        while (ref_pos != 71) step_once();
        check_all("R2 step 71");
        step_once();
        check_all("R2 wrap to 0");
        step_once();
        check_all("R2 after wrap");

        // Back-to-back steps: R2
        @(negedge clk) step_en = 1'b1;
        repeat (3) @(negedge clk);
        step_en = 1'b0;
        ref_pos = (ref_pos + 3) % 72;
        check_all("R2 consecutive");

        // Reset mid-period: R1
        while (ref_pos != 40) step_once();
        @(negedge clk) rst_n = 1'b0;
        ref_pos = 0;
        @(negedge clk);
        check_all("R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 post reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule